// File: doc/BRIEF.md
# Interrupt Acknowledge Priority Chain

This block answers an interrupt acknowledge command on behalf of a row of device slots laid out along a bus. Each slot reports whether its device is waiting for service and whether the program has disabled that device, and it carries a fixed 6-bit device code. When the processor raises acknowledge, the block finds the waiting, enabled device that sits closest to the processor. It then places that device's code on a 16-bit result word.

Priority follows position in the chain, not the value of the code. Slot 0 is nearest the processor, and each slot passes a priority token to the next slot only when it is not claiming the acknowledge itself. The decision uses only the request levels present in the acknowledge cycle. If no slot qualifies, the result reads as zero. The result is registered and holds until the next acknowledge. The service routine reads it as an identification word.

Top module: `irq_ack_chain`

## Requirements
- R1: While rst_n is low at a clock edge, data_o becomes all zeros on that edge.
- R2: On a clock edge with ack_i high, data_o takes the code of the lowest-numbered slot i that has wait_i[i]=1 and disable_i[i]=0. Slot i's code is code_i[i*6+5 : i*6].
- R3: A slot with disable_i[i]=1 is never selected, even when its wait_i bit is set.
- R4: On a clock edge with ack_i high and no slot both waiting and enabled, data_o becomes all zeros.
- R5: data_o changes only on a clock edge with ack_i high, one cycle after the acknowledge is presented. With ack_i low, changes on wait_i, disable_i and code_i leave data_o unchanged.
- R6: The device code occupies data_o[5:0], and data_o[15:6] is always zero.
- R7: At most one slot is granted in any cycle, and exactly one is granted whenever at least one slot is waiting and enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ack_i | input | 1 | Acknowledge command, sampled on the clock edge |
| wait_i | input | 8 | Per-slot waiting-request level; bit 0 is nearest the processor |
| disable_i | input | 8 | Per-slot interrupt-disable flag; a set bit removes the slot |
| code_i | input | 48 | Strapped 6-bit device codes; slot i uses bits i*6+5 to i*6 |
| data_o | output | 16 | Registered acknowledge result: the code in bits 5:0, zeros above |

## Verification
Single-slot patterns show that each slot's code reaches the output without any mixing between slots. Several waiting slots together with varied disable masks show whether the nearest enabled slot wins or whether a masked nearer slot wrongly takes the token. The all-disabled and all-idle cases confirm the zero result. Request and mask changes made while acknowledge is low confirm that the held word ignores them. A long stretch of random wait, disable and acknowledge values is compared on every clock against a behavioural search for the first qualifying slot.

// File: rtl/irq_ack_pkg.sv
// Package: shared sizing defaults for the interrupt acknowledge chain.
// Assumes slot 0 is electrically nearest the processor.
package irq_ack_pkg;
    localparam int DEF_SLOTS  = 8;
    localparam int DEF_CODE_W = 6;
    localparam int DEF_DATA_W = 16;
endpackage

// File: rtl/ack_slot_cell.sv
// One link of the priority ripple. A slot claims the token when it holds
// the token, is waiting, and is not disabled. It passes the token on only
// when it does not claim it. Its code is gated onto the shared result
// only when the slot claims the token.
module ack_slot_cell #(
    parameter int CODE_W = 6
) (
    input  logic              pri_in,
    input  logic              wait_req,
    input  logic              dis_flag,
    input  logic [CODE_W-1:0] dev_code,
    output logic              pri_out,
    output logic              grant,
    output logic [CODE_W-1:0] gated_code
);
    logic eligible;

    // Decide the claim and forward the token to the next slot.
    always_comb begin
        eligible   = wait_req & ~dis_flag;
        grant      = pri_in & eligible;
        pri_out    = pri_in & ~eligible;
        gated_code = grant ? dev_code : '0;
    end
endmodule

// File: rtl/ack_priority_chain.sv
// Builds the chain of slot cells in physical order and ORs the gated
// codes together. At most one cell is granted, so the OR forms a clean
// select. Assumes the inputs are stable for the acknowledge cycle.
module ack_priority_chain #(
    parameter int SLOTS  = 8,
    parameter int CODE_W = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [SLOTS-1:0]        wait_req,
    input  logic [SLOTS-1:0]        dis_flag,
    input  logic [SLOTS*CODE_W-1:0] code_bus,
    output logic [SLOTS-1:0]        grant_vec,
    output logic                    any_hit,
    output logic [CODE_W-1:0]       win_code
);
    logic [SLOTS:0]        token;
    logic [CODE_W-1:0]     gated [SLOTS];
    logic [CODE_W-1:0]     acc   [SLOTS+1];

    assign token[0] = 1'b1;
    assign acc[0]   = '0;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        ack_slot_cell #(.CODE_W(CODE_W)) i_cell (
            .pri_in     (token[s]),
            .wait_req   (wait_req[s]),
            .dis_flag   (dis_flag[s]),
            .dev_code   (code_bus[s*CODE_W +: CODE_W]),
            .pri_out    (token[s+1]),
            .grant      (grant_vec[s]),
            .gated_code (gated[s])
        );
        // Accumulate the gated code of this slot into the running OR.
        always_comb acc[s+1] = acc[s] | gated[s];
    end

    // Expose the final result and whether any slot claimed the token.
    always_comb begin
        win_code = acc[SLOTS];
        any_hit  = ~token[SLOTS];
    end

    assert_one_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_vec));
    assert_grant_when_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(wait_req & ~dis_flag)) |-> (|grant_vec));
    assert_no_masked_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vec & dis_flag) == '0);
endmodule

// File: rtl/ack_result_reg.sv
// Holds the acknowledge result word. It loads the zero-extended winning
// code when acknowledge is high and keeps its value otherwise. Assumes
// DATA_W >= CODE_W.
module ack_result_reg #(
    parameter int CODE_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ack,
    input  logic              hit,
    input  logic [CODE_W-1:0] code,
    output logic [DATA_W-1:0] data_q
);
    localparam int PAD_W = DATA_W - CODE_W;

    // Capture the result on acknowledge, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= '0;
        else if (ack)
            data_q <= {{PAD_W{1'b0}}, code};
    end

    assert_hold_without_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |=> $stable(data_q));
    assert_empty_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !hit) |=> (data_q == '0));
    assert_load_winner_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && hit) |=> (data_q[CODE_W-1:0] == $past(code)));
endmodule

// File: rtl/irq_ack_chain.sv
// Top of the interrupt acknowledge priority chain. It resolves the nearest
// waiting, enabled slot and registers its code for the acknowledge reader.
// Assumes a synchronous active-low reset and strapped device codes.
module irq_ack_chain
    import irq_ack_pkg::*;
#(
    parameter int SLOTS  = DEF_SLOTS,
    parameter int CODE_W = DEF_CODE_W,
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ack_i,
    input  logic [SLOTS-1:0]        wait_i,
    input  logic [SLOTS-1:0]        disable_i,
    input  logic [SLOTS*CODE_W-1:0] code_i,
    output logic [DATA_W-1:0]       data_o
);
    logic [SLOTS-1:0]  grant_vec;
    logic              any_hit;
    logic [CODE_W-1:0] win_code;

    ack_priority_chain #(.SLOTS(SLOTS), .CODE_W(CODE_W)) i_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .wait_req  (wait_i),
        .dis_flag  (disable_i),
        .code_bus  (code_i),
        .grant_vec (grant_vec),
        .any_hit   (any_hit),
        .win_code  (win_code)
    );

    ack_result_reg #(.CODE_W(CODE_W), .DATA_W(DATA_W)) i_result (
        .clk    (clk),
        .rst_n  (rst_n),
        .ack    (ack_i),
        .hit    (any_hit),
        .code   (win_code),
        .data_q (data_o)
    );

    assert_nearest_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && wait_i[0] && !disable_i[0]) |=> (data_o[CODE_W-1:0] == $past(code_i[CODE_W-1:0])));
    assert_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        data_o[DATA_W-1:CODE_W] == '0);
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (data_o == '0));
endmodule

// File: tb/test_irq_ack_chain.sv
module test_irq_ack_chain;
    localparam int CLK_PERIOD = 10;
    localparam int SLOTS  = 8;
    localparam int CODE_W = 6;
    localparam int DATA_W = 16;
    localparam int WATCHDOG = 20000;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    ack_i = 1'b0;
    logic [SLOTS-1:0]        wait_i = '0;
    logic [SLOTS-1:0]        disable_i = '0;
    logic [SLOTS*CODE_W-1:0] code_i;
    logic [DATA_W-1:0]       data_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;
    logic [DATA_W-1:0] model_q = '0;

    irq_ack_chain i_irq_ack_chain (
        .clk(clk), .rst_n(rst_n), .ack_i(ack_i), .wait_i(wait_i),
        .disable_i(disable_i), .code_i(code_i), .data_o(data_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int code_of(int s);
        return 6'h11 + s * 5;
    endfunction

    initial begin
        for (int s = 0; s < SLOTS; s++) code_i[s*CODE_W +: CODE_W] = CODE_W'(code_of(s));
    end

    // Behavioural model: search for the first waiting, enabled slot.
    function automatic logic [DATA_W-1:0] expect_word(logic [SLOTS-1:0] w, logic [SLOTS-1:0] d);
        for (int s = 0; s < SLOTS; s++)
            if (w[s] && !d[s]) return DATA_W'(code_of(s));
        return '0;
    endfunction

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst_n) model_q <= '0;
        else if (ack_i) model_q <= expect_word(wait_i, disable_i);
    end

    task automatic check(string req, logic [DATA_W-1:0] exp);
        checks++;
        if (data_o !== exp) begin
            errors++;
            $display("FAIL %s: data_o=%h expected=%h", req, data_o, exp);
        end
    endtask

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !done) check("R2/R4/R5 model", model_q);
    end

    task automatic finish_run;
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(negedge clk) begin
        if (cycles > WATCHDOG && !done) begin
            errors++;
            $display("FAIL watchdog: cycles=%0d expected<=%0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    task automatic do_ack(logic [SLOTS-1:0] w, logic [SLOTS-1:0] d);
        @(negedge clk);
        wait_i = w; disable_i = d; ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", '0);

        for (int s = 0; s < SLOTS; s++) begin
            do_ack(SLOTS'(1) << s, '0);
            check("R2 single slot", DATA_W'(code_of(s)));
        end
        do_ack(8'b1010_1100, '0);
        check("R2 nearest of several", DATA_W'(code_of(2)));
        do_ack(8'hFF, '0);
        check("R2 all waiting", DATA_W'(code_of(0)));
        do_ack(8'b1010_1100, 8'b0000_0100);
        check("R3 masked nearer skipped", DATA_W'(code_of(3)));
        do_ack(8'hFF, 8'h7F);
        check("R3 only last enabled", DATA_W'(code_of(7)));
        do_ack(8'hFF, 8'hFF);
        check("R4 all disabled", '0);
        do_ack(8'h40, '0);
        check("R6 upper bits zero", DATA_W'(code_of(6)));
        do_ack('0, '0);
        check("R4 nobody waiting", '0);

        do_ack(8'h20, '0);
        @(negedge clk);
        wait_i = 8'h01; disable_i = '0;
        @(negedge clk);
        wait_i = '0; disable_i = 8'hFF;
        @(negedge clk);
        check("R5 hold without ack", DATA_W'(code_of(5)));

        @(negedge clk);
        wait_i = 8'h02; disable_i = '0; ack_i = 1'b1;
        #1 check("R5 no change before edge", DATA_W'(code_of(5)));
        @(negedge clk);
        ack_i = 1'b0;
        check("R5 one cycle after ack", DATA_W'(code_of(1)));

        for (int n = 0; n < 600; n++) begin
            @(negedge clk);
            wait_i    = SLOTS'($urandom);
            disable_i = SLOTS'($urandom) & SLOTS'($urandom);
            ack_i     = ($urandom % 3) != 0;
        end
        @(negedge clk);
        ack_i = 1'b0;

        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-run", '0);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end
endmodule